// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block is a synchronous controller for a 256K-word by 4-bit asynchronous DRAM. A host presents read and write requests made of an 18-bit word address, 4 bits of write data and a valid/ready handshake. Each request is turned into a strobe sequence on nine shared address pins. The upper nine address bits go out with the row strobe and the lower nine with the column strobe. Read data is captured from the memory while the column strobe is still low and is returned as a one-cycle response.

Back-to-back requests that share a row are served in fast-page fashion: the row stays open and only the column strobe cycles. A request to a different row, or the absence of a follow-on request, closes the row and starts a precharge. Every timing limit is a parameter counted in clock cycles. A refresh scheduler asks for the memory through a request line. It is granted only when no access holds the row strobe low, and only after the row-cycle time has elapsed.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is asserted and right after it, the row strobe, column strobe, write strobe and output enable are all high (inactive), `rsp_valid` is 0 and `ref_gnt` is 0.
- R2: When the row strobe falls, `dram_a` carries request address bits [17:9]. When the column strobe falls, it carries bits [8:0].
- R3: A read returns, as a single-cycle `rsp_valid` pulse, the 4-bit value last written to that address (or the memory's prior content). Responses come in request order.
- R4: The column strobe is low only while the row strobe is low. It falls at least T_RCD cycles after the row strobe. It stays low at least max(T_CAS, T_AA) cycles. On reads it rises no earlier than T_RAC cycles after the row strobe fell.
- R5: The row strobe stays high at least T_RP cycles between accesses. Two row strobe falls are at least T_RC cycles apart.
- R6: A write is an early write. The write strobe is already low in the cycle before the column strobe falls. The output enable stays high and the data bus is driven for the whole access.
- R7: A request accepted while a row is open and whose row matches is served by a column strobe cycle alone, with the row strobe held low.
- R8: A row mismatch or a missing follow-on request closes the row. The next access then opens with a fresh row strobe fall.
- R9: `ref_gnt` is asserted only while both strobes are high. A pending refresh request wins over a host request presented in the same cycle: `req_ready` stays 0 until refresh is released.
- R10: The write strobe does not change while the column strobe is low. It falls only in a cycle in which the column strobe was high in both this cycle and the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address (row = [17:9], column = [8:0]) |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh scheduler asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh scheduler |
| dram_a | output | 9 | Multiplexed address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data to memory |
| dram_dq_oe | output | 1 | Drive enable for write data |
| dram_dq_in | input | 4 | Data from memory |

## Verification
A refresh request and a host request can reach the sequencer in the same idle cycle. A refresh request can also arrive while an open row would take a page hit. A directed case raises both lines on one falling edge and checks that `req_ready` stays low, that the grant follows with both strobes high, and that the held request completes correctly once refresh is dropped. During the random phase, refresh pulses are raised at random moments against a stream that clusters on four rows. A strobe monitor judges every access for row and column timing, precharge, early-write ordering and write-strobe stability, and a model memory judges each read value.

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int DW    = 4,
  parameter int T_RCD = 3,
  parameter int T_CAS = 3,
  parameter int T_AA  = 5,
  parameter int T_RAC = 9,
  parameter int T_RP  = 8,
  parameter int T_RC  = 17
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_we,
  input  logic [ROW_W+COL_W-1:0]                 req_addr,
  input  logic [DW-1:0]                          req_wdata,
  output logic                                   rsp_valid,
  output logic [DW-1:0]                          rsp_rdata,
  input  logic                                   ref_req,
  output logic                                   ref_gnt,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]   dram_a,
  output logic                                   dram_ras_n,
  output logic                                   dram_cas_n,
  output logic                                   dram_we_n,
  output logic                                   dram_oe_n,
  output logic [DW-1:0]                          dram_dq_out,
  output logic                                   dram_dq_oe,
  input  logic [DW-1:0]                          dram_dq_in
);
  localparam int AW     = ROW_W + COL_W;
  localparam int MW     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_COL  = (T_CAS > T_AA) ? T_CAS : T_AA;
  localparam int S1     = (T_RC > T_RAC) ? T_RC : T_RAC;
  localparam int S2     = (T_RP > T_COL) ? T_RP : T_COL;
  localparam int S3     = (S1 > S2) ? S1 : S2;
  localparam int SAT    = (S3 > T_RCD) ? S3 : T_RCD;
  localparam int CW     = $clog2(SAT + 1);
  localparam logic [CW-1:0] SATV   = CW'(SAT);
  localparam logic [CW-1:0] RCD_M1 = CW'(T_RCD - 1);
  localparam logic [CW-1:0] COL_M1 = CW'(T_COL - 1);
  localparam logic [CW-1:0] RAC_M1 = CW'(T_RAC - 1);
  localparam logic [CW-1:0] RP_M1  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RC_M1  = CW'(T_RC - 1);
  localparam logic [CW-1:0] RP_V   = CW'(T_RP);
  localparam logic [CW-1:0] COL_V  = CW'(T_COL);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_OPEN, S_PREP, S_PRE, S_REF} st_t;

  st_t            st, st_nx;
  logic [CW-1:0]  cnt, ras_age;
  logic [AW-1:0]  cur_addr;
  logic           cur_we;
  logic [DW-1:0]  cur_wd;

  wire trc_ok = ras_age >= RC_M1;
  wire hit    = req_addr[AW-1 -: ROW_W] == cur_addr[AW-1 -: ROW_W];
  assign req_ready = !ref_req && ((st == S_IDLE && trc_ok) || (st == S_OPEN && hit));
  wire take   = req_valid && req_ready;
  wire rd_end = st == S_COL && st_nx == S_OPEN && !cur_we;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (ref_req && trc_ok) st_nx = S_REF;
              else if (take)         st_nx = S_ROW;
      S_ROW:  if (cnt >= RCD_M1) st_nx = S_COL;
      S_COL:  if (cnt >= COL_M1 && ras_age >= RAC_M1) st_nx = S_OPEN;
      S_OPEN: st_nx = take ? S_PREP : S_PRE;
      S_PREP: st_nx = S_COL;
      S_PRE:  if (cnt >= RP_M1) st_nx = S_IDLE;
      S_REF:  if (!ref_req) st_nx = S_PRE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ras_age   <= SATV;
      cur_addr  <= '0;
      cur_we    <= 1'b0;
      cur_wd    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_nx;
      cnt       <= (st_nx != st) ? '0 : (cnt == SATV ? cnt : cnt + 1'b1);
      ras_age   <= (st == S_IDLE && take) ? '0 : (ras_age == SATV ? ras_age : ras_age + 1'b1);
      rsp_valid <= rd_end;
      if (rd_end) rsp_rdata <= dram_dq_in;
      if (take) begin
        cur_addr <= req_addr;
        cur_we   <= req_we;
        cur_wd   <= req_wdata;
      end
    end
  end

  wire row_low = st == S_ROW || st == S_COL || st == S_OPEN || st == S_PREP;
  wire wr_win  = cur_we && (st == S_ROW || st == S_COL || st == S_PREP);

  assign dram_ras_n  = !row_low;
  assign dram_cas_n  = st != S_COL;
  assign dram_we_n   = !wr_win;
  assign dram_oe_n   = !(st == S_COL && !cur_we);
  assign dram_dq_oe  = wr_win;
  assign dram_dq_out = cur_wd;
  assign ref_gnt     = st == S_REF;
  assign dram_a      = (st == S_ROW) ? MW'(cur_addr[AW-1 -: ROW_W]) : MW'(cur_addr[COL_W-1:0]);

  logic [CW-1:0] hi_cnt, lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= SATV;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= !dram_ras_n ? '0 : (hi_cnt == SATV ? hi_cnt : hi_cnt + 1'b1);
      lo_cnt <= dram_cas_n ? '0 : (lo_cnt == SATV ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n); // R4
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> lo_cnt >= COL_V); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_cnt >= RP_V); // R5
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R6
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (dram_we_n && !dram_dq_oe)); // R6
  AST_WE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_we_n)); // R10
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!dram_cas_n)); // R3
endmodule

// File: tb/sim_dram_page_seq.sv
module sim_dram_page_seq;
  localparam int CLK_P = 10;
  localparam int T_RCD = 3, T_CAS = 3, T_AA = 5, T_RAC = 9, T_RP = 8, T_RC = 17;
  localparam int T_COL = (T_CAS > T_AA) ? T_CAS : T_AA;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ref_req = 0;
  logic [17:0] req_addr = '0;
  logic [3:0] req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rsp_valid, ref_gnt;
  logic [3:0] rsp_rdata, dram_dq_out;
  logic [8:0] dram_a;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #(CLK_P/2) clk = ~clk;

  dram_page_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int nchk = 0, nbad = 0;
  int ras_falls = 0, cas_falls = 0;
  logic [3:0] smem [logic [17:0]];
  logic [3:0] emem [logic [17:0]];
  logic [3:0] expq [$];
  logic [17:0] cur_a = '0;
  logic [8:0] srow = '0;
  bit rdone = 0;

  function automatic logic [3:0] seed_val(logic [17:0] a);
    return a[3:0] ^ a[12:9] ^ a[17:14] ^ 4'h5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input bit we, input logic [17:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    cur_a = a;
    if (we) emem[a] = d;
    else expq.push_back(emem.exists(a) ? emem[a] : seed_val(a));
    @(posedge clk);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // strobe monitor, memory stub and response checker
  int ras_age_b = 1000, hi_b = 1000, lo_b = 0;
  bit pr = 1, pc = 1, pw = 1, rd_acc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pr = 1; pc = 1; pw = 1;
    end else begin
      if (pr && !dram_ras_n) begin
        chk(hi_b >= T_RP, "R5 precharge", hi_b, T_RP);
        chk(ras_age_b >= T_RC, "R5 row cycle", ras_age_b, T_RC);
        chk(dram_a == cur_a[17:9], "R2 row address", dram_a, cur_a[17:9]);
        ras_falls++; ras_age_b = 0; srow = dram_a;
      end else ras_age_b++;
      hi_b = dram_ras_n ? hi_b + 1 : 0;
      if (!dram_cas_n) chk(!dram_ras_n, "R4 cas under ras", dram_ras_n, 0);
      if (pc && !dram_cas_n) begin
        cas_falls++;
        chk(ras_age_b >= T_RCD, "R4 ras to cas", ras_age_b, T_RCD);
        chk(dram_a == cur_a[8:0], "R2 column address", dram_a, cur_a[8:0]);
        rd_acc = dram_we_n;
        if (!dram_we_n) begin
          chk(!pw, "R6 early write", pw, 0);
          chk(dram_oe_n && dram_dq_oe, "R6 bus drive", {dram_oe_n, dram_dq_oe}, 3);
          smem[{srow, dram_a}] = dram_dq_out;
        end
        lo_b = 0;
      end
      if (!dram_cas_n) lo_b++;
      if (!pc && dram_cas_n) begin
        chk(lo_b >= T_COL, "R4 cas width", lo_b, T_COL);
        if (rd_acc) chk(ras_age_b >= T_RAC, "R4 ras access", ras_age_b, T_RAC);
      end
      if (!pc && !dram_cas_n) chk(dram_we_n == pw, "R10 we held", dram_we_n, pw);
      if (pw && !dram_we_n) chk(pc && dram_cas_n, "R10 we fall", {pc, dram_cas_n}, 3);
      if (ref_gnt) chk(dram_ras_n && dram_cas_n, "R9 grant quiet", {dram_ras_n, dram_cas_n}, 3);
      if (!dram_cas_n && !dram_oe_n)
        dram_dq_in = smem.exists({srow, dram_a}) ? smem[{srow, dram_a}] : seed_val({srow, dram_a});
      else dram_dq_in = 4'h0;
      if (rsp_valid) begin
        if (expq.size() == 0) chk(0, "R3 unexpected response", rsp_rdata, -1);
        else begin
          logic [3:0] e;
          e = expq.pop_front();
          chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
        end
      end
      pr = dram_ras_n; pc = dram_cas_n; pw = dram_we_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int r0, c0;
    logic [8:0] rows [4];
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!rsp_valid && !ref_gnt, "R1 outputs in reset", {rsp_valid, ref_gnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !ref_gnt, "R1 after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, ref_gnt}, 30);

    // directed write then read
    do_req(1, {9'd5, 9'd10}, 4'h9);
    go_idle(30);
    do_req(0, {9'd5, 9'd10}, 4'h0);
    go_idle(30);
    do_req(0, {9'd300, 9'd511}, 4'h0);
    go_idle(30);

    // page burst, R7
    r0 = ras_falls; c0 = cas_falls;
    do_req(0, {9'd7, 9'd1}, 0);
    do_req(1, {9'd7, 9'd2}, 4'hC);
    do_req(0, {9'd7, 9'd2}, 0);
    do_req(0, {9'd7, 9'd400}, 0);
    go_idle(40);
    chk(ras_falls - r0 == 1, "R7 one row open", ras_falls - r0, 1);
    chk(cas_falls - c0 == 4, "R7 column cycles", cas_falls - c0, 4);

    // row miss, R8
    r0 = ras_falls;
    do_req(0, {9'd8, 9'd3}, 0);
    do_req(0, {9'd9, 9'd3}, 0);
    go_idle(40);
    chk(ras_falls - r0 == 2, "R8 row reopened", ras_falls - r0, 2);

    // refresh and host request in the same cycle, R9
    @(negedge clk);
    ref_req = 1; req_valid = 1; req_we = 0; req_addr = {9'd5, 9'd10};
    #1;
    chk(!req_ready, "R9 refresh wins", req_ready, 0);
    @(negedge clk);
    chk(ref_gnt, "R9 grant", ref_gnt, 1);
    repeat (3) @(negedge clk);
    chk(ref_gnt && !req_ready, "R9 grant held", {ref_gnt, req_ready}, 2);
    ref_req = 0;
    do_req(0, {9'd5, 9'd10}, 0);
    go_idle(40);

    // random mix with random refresh
    for (int i = 0; i < 4; i++) rows[i] = 9'($urandom);
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          do_req(1'($urandom), {rows[$urandom % 4], 9'($urandom)}, 4'($urandom));
          if ($urandom % 4 == 0) go_idle($urandom % 6);
        end
        go_idle(2);
        rdone = 1;
      end
      begin
        while (!rdone) begin
          repeat (20 + $urandom % 60) @(negedge clk);
          if (!rdone) begin
            ref_req = 1;
            while (!ref_gnt) @(negedge clk);
            repeat (3) @(negedge clk);
            ref_req = 0;
          end
        end
      end
    join
    go_idle(60);
    chk(expq.size() == 0, "R3 all reads answered", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule